// File: doc/BRIEF.md
# Temperature Sensor Two-Wire Register Slave

This block is the bus-facing front end of a temperature sensor. It watches an already-synchronised two-wire clock and data pair, recognises bus start and stop conditions, answers to one of four 7-bit device addresses picked by a 2-bit strap input, and pulls the data line low through an open-drain enable whenever it acknowledges or sends a zero.

Register access goes through a 2-bit pointer. The first byte of every write transaction is stored as the pointer. Any later bytes form 16-bit values, high byte first, that land in the selected register. A read transaction returns the register that the stored pointer selects, and the pointer is kept across stop and repeated start. The live temperature arrives on a parallel port and is read-only. Two limit registers hold left-justified values whose unused low bits are forced to zero, with a width that depends on an extended-range bit in the configuration register. The limit and configuration values are exported for the alert logic downstream.

Top module: `tsens_i2c_slave`

## Requirements
- R1: A start condition (data falling while clock is high) restarts address reception from any state, and a partly received data byte is discarded. A stop condition (data rising while clock is high) returns the block to idle and releases the data line.
- R2: The address byte is received on rising clock edges, MSB first, 7 address bits then the direction bit (1 = read). The device address is binary 10010 followed by the 2 strap bits. On a match the block pulls data low for the whole ninth clock.
- R3: On an address mismatch the block drives nothing, not even for a later byte that carries its own address, until the next start condition.
- R4: The first byte after a write address sets the pointer from its low 2 bits: 00 temperature, 01 configuration, 10 low limit, 11 high limit. A write that stops after the pointer byte changes no register.
- R5: In a write, each byte after the pointer is acknowledged. The first is the high byte and the second is the low byte, and the register is updated once both have arrived.
- R6: A read returns the register selected by the last stored pointer. The pointer resets to 00 and keeps its value through stop and repeated start.
- R7: Read data goes out MSB first, high byte then low byte. A master acknowledge fetches the next byte (after the low byte the high byte comes again). A master not-acknowledge releases the data line until the next start or stop.
- R8: Writes to the temperature pointer are acknowledged but change nothing, and reading it returns the parallel temperature input.
- R9: After reset the high limit is 16'h5000, the low limit 16'h4B00, the configuration 16'h0000 and the data line is released.
- R10: While configuration bit 4 is 0, limit writes clear bits 3:0. While it is 1, they clear bits 2:0.
- R11: The data pull-down enable is only ever asserted while the clock line is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Synchronised bus clock level |
| sda_i | input | 1 | Synchronised bus data level |
| addr_sel_i | input | 2 | Strap selecting the low two address bits |
| temp_i | input | 16 | Current temperature code |
| sda_oe_o | output | 1 | Active-high pull-down enable for the data line |
| cfg_o | output | 16 | Configuration register |
| tlow_o | output | 16 | Low limit register |
| thigh_o | output | 16 | High limit register |

## Verification
The bench sweeps all 128 addresses against all four strap settings. An off-by-one in the address compare or in the strap decode shows up as a missing or extra acknowledge, and a device that recovers from a mismatch too early acknowledges the follow-up byte that carries its own address. It writes arithmetic value patterns into the limit registers in both range modes. A mask off by one bit, or applied with the wrong mode, reads back a stray low bit. It also covers a write that stops after the pointer, a repeated start used to switch from write to read, a start that cuts a data byte short, and reads that run past the low byte. A design that lost the pointer at stop, wrote half a value, or kept driving after a not-acknowledge would return wrong data or hold the line low.

// File: rtl/tsens_i2c_pkg.sv
package tsens_i2c_pkg;
  localparam int BYTE_W = 8;
  localparam int REG_W  = 2 * BYTE_W;
  localparam int PTR_W  = 2;

  typedef enum logic [PTR_W-1:0] {
    PTR_TEMP  = 2'b00,
    PTR_CFG   = 2'b01,
    PTR_TLOW  = 2'b10,
    PTR_THIGH = 2'b11
  } ptr_t;

  typedef enum logic [2:0] {
    LS_IDLE,
    LS_RX,
    LS_ACK,
    LS_TX,
    LS_RACK,
    LS_WAIT
  } link_st_t;
endpackage

// File: rtl/tsens_bus_cond.sv
module tsens_bus_cond (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic start_o,
  output logic stop_o,
  output logic rise_o,
  output logic fall_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign start_o = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_o  = scl_i & scl_q & ~sda_q & sda_i;
  assign rise_o  = scl_i & ~scl_q;
  assign fall_o  = ~scl_i & scl_q;
endmodule

// File: rtl/tsens_regs.sv
module tsens_regs
  import tsens_i2c_pkg::*;
#(
  parameter logic [REG_W-1:0] THIGH_RST = 16'h5000,
  parameter logic [REG_W-1:0] TLOW_RST  = 16'h4B00,
  parameter logic [REG_W-1:0] CFG_RST   = 16'h0000,
  parameter int               EXT_BIT   = 4,
  parameter int               NRM_ZB    = 4,
  parameter int               EXT_ZB    = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en_i,
  input  logic [PTR_W-1:0] wr_sel_i,
  input  logic [REG_W-1:0] wr_data_i,
  input  logic [PTR_W-1:0] rd_sel_i,
  input  logic [REG_W-1:0] temp_i,
  output logic [REG_W-1:0] rd_data_o,
  output logic [REG_W-1:0] cfg_o,
  output logic [REG_W-1:0] tlow_o,
  output logic [REG_W-1:0] thigh_o
);
  localparam logic [REG_W-1:0] NRM_MASK = {REG_W{1'b1}} << NRM_ZB;
  localparam logic [REG_W-1:0] EXT_MASK = {REG_W{1'b1}} << EXT_ZB;

  logic [REG_W-1:0] cfg_q, tlow_q, thigh_q;
  logic [REG_W-1:0] lim_mask, lim_val;
  logic             cfg_en, tlow_en, thigh_en;

  assign lim_mask = cfg_q[EXT_BIT] ? EXT_MASK : NRM_MASK;
  assign lim_val  = wr_data_i & lim_mask;
  assign cfg_en   = wr_en_i & (ptr_t'(wr_sel_i) == PTR_CFG);
  assign tlow_en  = wr_en_i & (ptr_t'(wr_sel_i) == PTR_TLOW);
  assign thigh_en = wr_en_i & (ptr_t'(wr_sel_i) == PTR_THIGH);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q   <= CFG_RST;
      tlow_q  <= TLOW_RST;
      thigh_q <= THIGH_RST;
    end else begin
      if (cfg_en)   cfg_q   <= wr_data_i;
      if (tlow_en)  tlow_q  <= lim_val;
      if (thigh_en) thigh_q <= lim_val;
    end
  end

  always_comb begin
    unique case (ptr_t'(rd_sel_i))
      PTR_TEMP:  rd_data_o = temp_i;
      PTR_CFG:   rd_data_o = cfg_q;
      PTR_TLOW:  rd_data_o = tlow_q;
      default:   rd_data_o = thigh_q;
    endcase
  end

  assign cfg_o   = cfg_q;
  assign tlow_o  = tlow_q;
  assign thigh_o = thigh_q;

  // R10
  lim_low_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tlow_q[EXT_ZB-1:0] == '0) && (thigh_q[EXT_ZB-1:0] == '0));
endmodule

// File: rtl/tsens_link.sv
module tsens_link
  import tsens_i2c_pkg::*;
#(
  parameter logic [4:0] ADDR_BASE = 5'b10010
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_i,
  input  logic             sda_i,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic             rise_i,
  input  logic             fall_i,
  input  logic [1:0]       addr_sel_i,
  input  logic [REG_W-1:0] rd_data_i,
  output logic [PTR_W-1:0] ptr_o,
  output logic             wr_en_o,
  output logic [REG_W-1:0] wr_data_o,
  output logic             sda_oe_o
);
  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BYTE_W - 1);

  link_st_t          st_q, st_n;
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic [BYTE_W-1:0] sh_q, sh_n, hold_q, hold_n, ld_byte;
  logic [REG_W-1:0]  snap_q, snap_n;
  logic [PTR_W-1:0]  ptr_q, ptr_n;
  logic              oe_q, oe_n, rw_q, rw_n, is_addr_q, is_addr_n;
  logic              is_ptr_q, is_ptr_n, lsb_q, lsb_n, nack_q, nack_n;
  logic              addr_hit;

  assign addr_hit = (sh_q[BYTE_W-1:1] == {ADDR_BASE, addr_sel_i});
  assign ld_byte  = lsb_q ? snap_q[BYTE_W-1:0] : rd_data_i[REG_W-1:BYTE_W];

  always_comb begin
    st_n = st_q; cnt_n = cnt_q; sh_n = sh_q; hold_n = hold_q;
    snap_n = snap_q; ptr_n = ptr_q; oe_n = oe_q; rw_n = rw_q;
    is_addr_n = is_addr_q; is_ptr_n = is_ptr_q; lsb_n = lsb_q; nack_n = nack_q;
    wr_en_o = 1'b0;
    wr_data_o = {hold_q, sh_q};
    if (start_i) begin
      st_n = LS_RX; cnt_n = '0; oe_n = 1'b0; is_addr_n = 1'b1; lsb_n = 1'b0;
    end else if (stop_i) begin
      st_n = LS_IDLE; oe_n = 1'b0;
    end else begin
      unique case (st_q)
        LS_RX: begin
          if (rise_i) begin
            sh_n  = {sh_q[BYTE_W-2:0], sda_i};
            cnt_n = cnt_q + 1'b1;
          end else if (fall_i && cnt_q == CNT_FULL) begin
            cnt_n = '0;
            st_n  = LS_ACK;
            oe_n  = 1'b1;
            if (is_addr_q) begin
              is_addr_n = 1'b0;
              rw_n      = sh_q[0];
              is_ptr_n  = ~sh_q[0];
              if (!addr_hit) begin
                st_n = LS_WAIT;
                oe_n = 1'b0;
              end
            end else if (is_ptr_q) begin
              ptr_n    = sh_q[PTR_W-1:0];
              is_ptr_n = 1'b0;
              lsb_n    = 1'b0;
            end else begin
              lsb_n = ~lsb_q;
              if (!lsb_q) hold_n  = sh_q;
              else        wr_en_o = 1'b1;
            end
          end
        end
        LS_ACK: begin
          if (fall_i) begin
            if (rw_q) begin
              if (!lsb_q) snap_n = rd_data_i;
              sh_n = ld_byte; oe_n = ~ld_byte[BYTE_W-1]; cnt_n = '0; st_n = LS_TX;
            end else begin
              oe_n = 1'b0; st_n = LS_RX;
            end
          end
        end
        LS_TX: begin
          if (fall_i) begin
            if (cnt_q == CNT_LAST) begin
              oe_n = 1'b0; st_n = LS_RACK; lsb_n = ~lsb_q;
            end else begin
              sh_n  = {sh_q[BYTE_W-2:0], 1'b0};
              oe_n  = ~sh_q[BYTE_W-2];
              cnt_n = cnt_q + 1'b1;
            end
          end
        end
        LS_RACK: begin
          if (rise_i) begin
            nack_n = sda_i;
          end else if (fall_i) begin
            if (nack_q) begin
              st_n = LS_WAIT;
            end else begin
              if (!lsb_q) snap_n = rd_data_i;
              sh_n = ld_byte; oe_n = ~ld_byte[BYTE_W-1]; cnt_n = '0; st_n = LS_TX;
            end
          end
        end
        default: oe_n = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= LS_IDLE; cnt_q <= '0; sh_q <= '0; hold_q <= '0; snap_q <= '0;
      ptr_q <= PTR_TEMP; oe_q <= 1'b0; rw_q <= 1'b0; is_addr_q <= 1'b0;
      is_ptr_q <= 1'b0; lsb_q <= 1'b0; nack_q <= 1'b0;
    end else begin
      st_q <= st_n; cnt_q <= cnt_n; sh_q <= sh_n; hold_q <= hold_n; snap_q <= snap_n;
      ptr_q <= ptr_n; oe_q <= oe_n; rw_q <= rw_n; is_addr_q <= is_addr_n;
      is_ptr_q <= is_ptr_n; lsb_q <= lsb_n; nack_q <= nack_n;
    end
  end

  assign ptr_o    = ptr_q;
  assign sda_oe_o = oe_q;

  // R11
  oe_rise_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(oe_q) |-> !$past(scl_i));
  // R1
  stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_i |=> !oe_q);
  // R3
  wait_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == LS_WAIT) |-> !oe_q);
  // R5
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_FULL);
endmodule

// File: rtl/tsens_i2c_slave.sv
module tsens_i2c_slave
  import tsens_i2c_pkg::*;
#(
  parameter logic [4:0] ADDR_BASE = 5'b10010
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_i,
  input  logic             sda_i,
  input  logic [1:0]       addr_sel_i,
  input  logic [REG_W-1:0] temp_i,
  output logic             sda_oe_o,
  output logic [REG_W-1:0] cfg_o,
  output logic [REG_W-1:0] tlow_o,
  output logic [REG_W-1:0] thigh_o
);
  logic [1:0]       rst_sync_q;
  logic             rst_n_s;
  logic             start, stop, rise, fall, wr_en;
  logic [PTR_W-1:0] ptr;
  logic [REG_W-1:0] wr_data, rd_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  tsens_bus_cond cond_i (
    .clk(clk), .rst_n(rst_n_s), .scl_i(scl_i), .sda_i(sda_i),
    .start_o(start), .stop_o(stop), .rise_o(rise), .fall_o(fall)
  );

  tsens_link #(.ADDR_BASE(ADDR_BASE)) link_i (
    .clk(clk), .rst_n(rst_n_s), .scl_i(scl_i), .sda_i(sda_i),
    .start_i(start), .stop_i(stop), .rise_i(rise), .fall_i(fall),
    .addr_sel_i(addr_sel_i), .rd_data_i(rd_data), .ptr_o(ptr),
    .wr_en_o(wr_en), .wr_data_o(wr_data), .sda_oe_o(sda_oe_o)
  );

  tsens_regs regs_i (
    .clk(clk), .rst_n(rst_n_s), .wr_en_i(wr_en), .wr_sel_i(ptr),
    .wr_data_i(wr_data), .rd_sel_i(ptr), .temp_i(temp_i),
    .rd_data_o(rd_data), .cfg_o(cfg_o), .tlow_o(tlow_o), .thigh_o(thigh_o)
  );
endmodule

// File: tb/tsens_i2c_slave_tb.sv
module tsens_i2c_slave_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 3;
  localparam logic [4:0] BASE = 5'b10010;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        m_scl = 1'b1, m_sda = 1'b1;
  logic [1:0]  strap = 2'b00;
  logic [15:0] temp = 16'h1A30;
  logic        sda_oe;
  logic [15:0] cfg, tlow, thigh;
  wire         sda_bus = m_sda & ~sda_oe;

  int checks = 0, errs = 0, viol = 0;
  bit done = 1'b0, prev_oe = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tsens_i2c_slave dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_bus),
    .addr_sel_i(strap), .temp_i(temp), .sda_oe_o(sda_oe),
    .cfg_o(cfg), .tlow_o(tlow), .thigh_o(thigh)
  );

  // R11 monitor: pull-down must never begin while clock is high
  always @(posedge clk) begin
    #1;
    if (sda_oe && !prev_oe && m_scl) viol++;
    prev_oe = sda_oe;
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_start();
    m_sda = 1'b1; tick(Q); m_scl = 1'b1; tick(Q); m_sda = 1'b0; tick(Q); m_scl = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; tick(Q); m_scl = 1'b1; tick(Q); m_sda = 1'b1; tick(Q);
  endtask

  task automatic wbyte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; tick(Q); m_scl = 1'b1; tick(Q); m_scl = 1'b0; tick(1);
    end
    m_sda = 1'b1; tick(Q); m_scl = 1'b1; tick(Q);
    ack = ~sda_bus;
    m_scl = 1'b0; tick(Q);
  endtask

  task automatic rbyte(input logic mack, output logic [7:0] b);
    m_sda = 1'b1;
    for (int i = 0; i < 8; i++) begin
      tick(Q); m_scl = 1'b1; tick(Q); b = {b[6:0], sda_bus}; m_scl = 1'b0;
    end
    tick(1); m_sda = ~mack; tick(Q); m_scl = 1'b1; tick(Q); m_scl = 1'b0; tick(1); m_sda = 1'b1;
  endtask

  function automatic logic [7:0] dev(input logic rd);
    return {BASE, strap, rd};
  endfunction

  task automatic wr_reg(input logic [1:0] p, input logic [15:0] v, output logic all_ack);
    logic a0, a1, a2, a3;
    bus_start(); wbyte(dev(1'b0), a0); wbyte({6'd0, p}, a1);
    wbyte(v[15:8], a2); wbyte(v[7:0], a3); bus_stop();
    all_ack = a0 & a1 & a2 & a3;
  endtask

  task automatic rd_reg(output logic [15:0] v);
    logic a;
    bus_start(); wbyte(dev(1'b1), a); rbyte(1'b1, v[15:8]); rbyte(1'b0, v[7:0]); bus_stop();
  endtask

  task automatic set_ptr(input logic [1:0] p);
    logic a0, a1;
    bus_start(); wbyte(dev(1'b0), a0); wbyte({6'd0, p}, a1); bus_stop();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errs);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++; errs++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic        ack, ack2;
    logic [15:0] rv, v, old;
    logic [7:0]  b0, b1, b2;
    tick(3); rst_n = 1'b1; tick(5);

    chk(sda_oe == 1'b0, "R9 oe at reset", {31'd0, sda_oe}, 0);
    chk(thigh == 16'h5000, "R9 high limit", {16'd0, thigh}, 32'h5000);
    chk(tlow == 16'h4B00, "R9 low limit", {16'd0, tlow}, 32'h4B00);
    chk(cfg == 16'h0000, "R9 config", {16'd0, cfg}, 0);
    rd_reg(rv);
    chk(rv == temp, "R6 R8 pointer reset to temperature", {16'd0, rv}, {16'd0, temp});

    // R2 R3: exhaustive address against strap sweep
    for (int s = 0; s < 4; s++) begin
      for (int a = 0; a < 128; a++) begin
        logic hit;
        strap = 2'(s); tick(2);
        hit = (7'(a) == {BASE, 2'(s)});
        bus_start(); wbyte({7'(a), 1'b0}, ack);
        chk(ack == hit, "R2 address ack", {31'd0, ack}, {31'd0, hit});
        if (!hit) begin
          wbyte(dev(1'b0), ack2);
          chk(!ack2, "R3 quiet after mismatch", {31'd0, ack2}, 0);
        end
        bus_stop();
      end
    end
    strap = 2'b10; tick(2);

    wr_reg(2'b11, 16'hABCD, ack);
    chk(ack, "R5 write bytes acked", {31'd0, ack}, 1);
    chk(thigh == 16'hABC0, "R10 high limit normal mask", {16'd0, thigh}, 32'hABC0);
    rd_reg(rv);
    chk(rv == 16'hABC0, "R6 read high limit", {16'd0, rv}, 32'hABC0);

    for (int k = 0; k < 8; k++) begin
      v = 16'(16'h1357 * (k + 1) + k);
      wr_reg(2'b10, v, ack);
      chk(tlow == (v & 16'hFFF0), "R5 R10 low limit write", {16'd0, tlow}, {16'd0, v & 16'hFFF0});
      rd_reg(rv);
      chk(rv == (v & 16'hFFF0), "R6 low limit read", {16'd0, rv}, {16'd0, v & 16'hFFF0});
    end

    old = tlow;
    set_ptr(2'b01);
    chk(tlow == old && thigh == 16'hABC0 && cfg == 16'h0, "R4 pointer-only write",
        {tlow, thigh}, {old, 16'hABC0});
    rd_reg(rv);
    chk(rv == 16'h0000, "R4 read config via pointer", {16'd0, rv}, 0);
    rd_reg(rv);
    chk(rv == 16'h0000, "R6 pointer persists", {16'd0, rv}, 0);

    wr_reg(2'b01, 16'h0010, ack);
    chk(cfg == 16'h0010, "R10 extended bit set", {16'd0, cfg}, 32'h10);
    wr_reg(2'b11, 16'hFFFF, ack);
    chk(thigh == 16'hFFF8, "R10 extended high mask", {16'd0, thigh}, 32'hFFF8);
    wr_reg(2'b10, 16'h000F, ack);
    chk(tlow == 16'h0008, "R10 extended low mask", {16'd0, tlow}, 32'h8);

    temp = 16'h7FF0;
    wr_reg(2'b00, 16'h5555, ack);
    chk(ack, "R8 temperature write acked", {31'd0, ack}, 1);
    rd_reg(rv);
    chk(rv == 16'h7FF0, "R8 temperature write ignored", {16'd0, rv}, 32'h7FF0);
    chk(thigh == 16'hFFF8 && tlow == 16'h0008 && cfg == 16'h0010, "R8 no register touched",
        {thigh, tlow}, {16'hFFF8, 16'h0008});

    // R6 R7: repeated start switches to read; read runs past the low byte
    bus_start(); wbyte(dev(1'b0), ack); wbyte(8'h03, ack);
    bus_start(); wbyte(dev(1'b1), ack);
    rbyte(1'b1, b0); rbyte(1'b1, b1); rbyte(1'b0, b2);
    chk({b0, b1, b2} == 24'hFFF8FF, "R7 byte order and wrap", {8'd0, b0, b1, b2}, 32'hFFF8FF);
    tick(2);
    chk(sda_oe == 1'b0, "R7 release after nack", {31'd0, sda_oe}, 0);
    m_scl = 1'b1; tick(Q);
    chk(sda_bus == 1'b1, "R7 quiet while waiting", {31'd0, sda_bus}, 1);
    m_scl = 1'b0; tick(Q);
    bus_stop();

    // R1: start cuts a data byte short
    bus_start(); wbyte(dev(1'b0), ack); wbyte(8'h02, ack); wbyte(8'h12, ack);
    for (int i = 0; i < 3; i++) begin
      m_sda = 1'b1; tick(Q); m_scl = 1'b1; tick(Q); m_scl = 1'b0; tick(1);
    end
    bus_start(); wbyte(dev(1'b1), ack);
    rbyte(1'b1, b0); rbyte(1'b0, b1); bus_stop();
    chk({b0, b1} == 16'h0008 && tlow == 16'h0008, "R1 start aborts write", {b0, b1, tlow}, 32'h00080008);

    // R1: stop in the middle of an address byte
    bus_start();
    for (int i = 0; i < 4; i++) begin
      m_sda = dev(1'b1)[7 - i]; tick(Q); m_scl = 1'b1; tick(Q); m_scl = 1'b0; tick(1);
    end
    bus_stop();
    chk(sda_oe == 1'b0, "R1 stop releases", {31'd0, sda_oe}, 0);
    rd_reg(rv);
    chk(rv == 16'h0008, "R1 normal access after stop", {16'd0, rv}, 32'h8);

    chk(viol == 0, "R11 pull-down only with clock low", viol, 0);
    finish_run();
  end
endmodule